// File: doc/BRIEF.md
# Transition-Coded Frame Encoder

This block turns a slow single-bit data line, already in NRZ form, into one byte per 125 µs frame for a 64 kbps channel. It does not send slot-by-slot samples. It watches the line across 32 timeslots and records where the first change happened, how many changes there were and how far apart they were. It also records the line level at the end of the frame. These facts are packed into an 8-bit code word. A decoder at the far end can rebuild the waveform from these words to within one timeslot.

A timeslot tick enable marks each of the 32 sampling points. A frame-start pulse given together with a tick marks slot 0. When the tick for slot 31 arrives, the block forms the word and offers it on a valid/ready output. The word stays on the port until the consumer accepts it. Back-pressure is not absorbed: the consumer must take each word within one frame. If a new frame finishes while a word is still pending, the newer word replaces the pending one, and the older word is lost. Frames always end on time and cannot be held back.

Top module: `tem_frame_encoder`

## Requirements
- R1: After reset, `code_valid` is low, and it stays low until the first frame has completed.
- R2: A tick with `frame_start` high is slot 0, and each later tick advances the slot by one, wrapping from 31 to 0. `code_valid` rises in the clock after the clock edge that samples the slot-31 tick, and never rises at any other time.
- R3: A transition is counted in a slot when the sampled bit differs from the bit sampled at the previous tick. This history carries across frame boundaries. The very first sample after reset counts as no transition.
- R4: Bit 7 of the code word equals the data bit sampled in slot 31 of that frame.
- R5: A frame with no transition codes bits 6..0 as 1111111.
- R6: A frame with one transition codes bits 6..5 as 10 and bits 4..0 as the slot of that transition.
- R7: A frame with exactly two transitions that are 12 to 14 slots apart, the first in slot 17 or lower, codes bits 6..5 as 11 and bits 4..0 as the first slot.
- R8: A frame with exactly three transitions, each pair of neighbours 12 to 14 slots apart, the first in slot 4 or lower, codes bits 6..5 as 11 and bits 4..0 as the first slot.
- R9: A frame with exactly two transitions that are 24 to 28 slots apart, the first in slot 4 or higher, codes bits 6..5 as 01 and bits 4..0 as the first slot.
- R10: A frame with exactly two transitions that are 24 to 28 slots apart, the first in slot 0 to 3, codes bits 6..5 as 00, bits 1..0 as the first slot, and bits 4..2 as the second slot minus 24.
- R11: Any other pattern of transitions (wrong spacing, a first slot out of range, or more than three transitions) is coded like a single transition: 10 in bits 6..5 and the first slot in bits 4..0.
- R12: While `code_valid` is high and `code_ready` is low, the word and the valid flag stay steady. The only exception is a newly completed frame, which overwrites the pending word.
- R13: A `frame_start` tick in the middle of a frame restarts counting at slot 0. The cut-short frame produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_tick | input | 1 | One-cycle enable marking a timeslot sampling point |
| frame_start | input | 1 | High with a tick to mark slot 0 |
| data_in | input | 1 | NRZ data line |
| code_ready | input | 1 | Consumer accepts the word when high with `code_valid` |
| code_valid | output | 1 | A code word is on offer |
| code_word | output | 8 | The frame's code word |

## Verification
On every cycle, the assertions check four things:
- the output handshake holds the word steady under back-pressure;
- a word appears only right after a slot-31 tick;
- the level bit follows the slot-31 sample;
- a quiet frame yields the all-ones pattern, and the first recorded transition slot never moves within a frame.

The bench scenarios are needed to show that each spacing class gets its correct tag and position field, including the boundaries between classes. They also show that the line history crosses the frame edge, that a restarted frame is silent, and that a pending word is overwritten.

// File: rtl/tem_enc_pkg.sv
package tem_enc_pkg;
  // Layout of the code word is fixed by the channel format.
  localparam int SLOT_W = 5;
  localparam int CODE_W = 8;
  localparam int CNT_W  = 3;

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [CODE_W-1:0] code_t;

  // Frame-type tag carried in bits 6..5.
  typedef enum logic [1:0] {
    TAG_LONG_EARLY = 2'b00,
    TAG_LONG_LATE  = 2'b01,
    TAG_SINGLE     = 2'b10,
    TAG_SHORT      = 2'b11
  } tag_e;

  // What the frame has seen so far.
  typedef struct packed {
    cnt_t  count;
    slot_t first;
    slot_t second;
    slot_t third;
  } edge_rec_t;
endpackage

// File: rtl/tem_slot_tracker.sv
module tem_slot_tracker
  import tem_enc_pkg::*;
#(
  parameter int SLOTS = 32
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  slot_tick,
  input  logic  frame_start,
  input  logic  data_in,
  output slot_t cur_slot,
  output logic  edge_seen,
  output logic  at_last
);
  localparam slot_t LAST = slot_t'(SLOTS - 1);

  slot_t slot_q;
  logic  prev_q;
  logic  hist_q;

  // Slot index for the tick being taken now.
  always_comb begin
    if (frame_start)          cur_slot = '0;
    else if (slot_q == LAST)  cur_slot = '0;
    else                      cur_slot = slot_q + slot_t'(1);
  end

  assign edge_seen = slot_tick && hist_q && (data_in != prev_q);
  assign at_last   = slot_tick && (cur_slot == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= LAST;
      prev_q <= 1'b0;
      hist_q <= 1'b0;
    end else if (slot_tick) begin
      slot_q <= cur_slot;
      prev_q <= data_in;
      hist_q <= 1'b1;
    end
  end

  // R13: a restart tick must leave the counter at slot 0 afterwards.
  p_restart_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick && frame_start |=> slot_q == '0);
endmodule

// File: rtl/tem_edge_log.sv
module tem_edge_log
  import tem_enc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      slot_tick,
  input  slot_t     cur_slot,
  input  logic      edge_seen,
  output edge_rec_t rec_next
);
  edge_rec_t rec_q;
  edge_rec_t base;

  always_comb begin
    base = (cur_slot == '0) ? '0 : rec_q;
    rec_next = base;
    if (edge_seen) begin
      case (base.count)
        cnt_t'(0): rec_next.first  = cur_slot;
        cnt_t'(1): rec_next.second = cur_slot;
        cnt_t'(2): rec_next.third  = cur_slot;
        default:   ;
      endcase
      if (base.count != '1) rec_next.count = base.count + cnt_t'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rec_q <= '0;
    else if (slot_tick) rec_q <= rec_next;
  end

  // R6: once a frame has a first transition, its slot is not overwritten.
  p_first_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    slot_tick && (cur_slot != '0) && (rec_q.count != '0)
    |=> rec_q.first == $past(rec_q.first));
endmodule

// File: rtl/tem_code_former.sv
module tem_code_former
  import tem_enc_pkg::*;
#(
  parameter int SHORT_MIN   = 12,
  parameter int SHORT_MAX   = 14,
  parameter int LONG_MIN    = 24,
  parameter int LONG_MAX    = 28,
  parameter int PAIR_LAST   = 17,
  parameter int TRIPLE_LAST = 4,
  parameter int EARLY_LAST  = 3
) (
  input  edge_rec_t rec,
  input  logic      level,
  output code_t     code
);
  localparam slot_t SH_LO  = slot_t'(SHORT_MIN);
  localparam slot_t SH_HI  = slot_t'(SHORT_MAX);
  localparam slot_t LG_LO  = slot_t'(LONG_MIN);
  localparam slot_t LG_HI  = slot_t'(LONG_MAX);
  localparam slot_t P_LAST = slot_t'(PAIR_LAST);
  localparam slot_t T_LAST = slot_t'(TRIPLE_LAST);
  localparam slot_t E_LAST = slot_t'(EARLY_LAST);
  localparam slot_t QUIET  = '1;
  localparam slot_t POS_MAX = slot_t'(7);

  slot_t gap1, gap2, pos2;
  logic  short1, short2, long1;
  code_t fallback;

  always_comb begin
    gap1   = rec.second - rec.first;
    gap2   = rec.third - rec.second;
    pos2   = rec.second - LG_LO;
    short1 = (gap1 >= SH_LO) && (gap1 <= SH_HI);
    short2 = (gap2 >= SH_LO) && (gap2 <= SH_HI);
    long1  = (gap1 >= LG_LO) && (gap1 <= LG_HI);
    fallback = {level, TAG_SINGLE, rec.first};
    code = fallback;
    if (rec.count == cnt_t'(0)) begin
      code = {level, TAG_SHORT, QUIET};
    end else if (rec.count == cnt_t'(2)) begin
      if (short1 && (rec.first <= P_LAST))
        code = {level, TAG_SHORT, rec.first};
      else if (long1 && (rec.first > E_LAST))
        code = {level, TAG_LONG_LATE, rec.first};
      else if (long1 && (rec.second >= LG_LO) && (pos2 <= POS_MAX))
        code = {level, TAG_LONG_EARLY, pos2[2:0], rec.first[1:0]};
    end else if (rec.count == cnt_t'(3)) begin
      if (short1 && short2 && (rec.first <= T_LAST))
        code = {level, TAG_SHORT, rec.first};
    end
  end
endmodule

// File: rtl/tem_frame_encoder.sv
module tem_frame_encoder
  import tem_enc_pkg::*;
#(
  parameter int SLOTS       = 32,
  parameter int SHORT_MIN   = 12,
  parameter int SHORT_MAX   = 14,
  parameter int LONG_MIN    = 24,
  parameter int LONG_MAX    = 28,
  parameter int PAIR_LAST   = 17,
  parameter int TRIPLE_LAST = 4,
  parameter int EARLY_LAST  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_tick,
  input  logic       frame_start,
  input  logic       data_in,
  input  logic       code_ready,
  output logic       code_valid,
  output logic [7:0] code_word
);
  slot_t     cur_slot;
  logic      edge_seen;
  logic      at_last;
  edge_rec_t rec_next;
  code_t     formed;

  tem_slot_tracker #(.SLOTS(SLOTS)) u_track (
    .clk, .rst_n, .slot_tick, .frame_start, .data_in,
    .cur_slot, .edge_seen, .at_last
  );

  tem_edge_log u_log (
    .clk, .rst_n, .slot_tick, .cur_slot, .edge_seen, .rec_next
  );

  tem_code_former #(
    .SHORT_MIN(SHORT_MIN), .SHORT_MAX(SHORT_MAX),
    .LONG_MIN(LONG_MIN), .LONG_MAX(LONG_MAX),
    .PAIR_LAST(PAIR_LAST), .TRIPLE_LAST(TRIPLE_LAST),
    .EARLY_LAST(EARLY_LAST)
  ) u_form (
    .rec(rec_next), .level(data_in), .code(formed)
  );

  // Output register: a new frame always wins over a pending word.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_valid <= 1'b0;
      code_word  <= '0;
    end else if (at_last) begin
      code_valid <= 1'b1;
      code_word  <= formed;
    end else if (code_valid && code_ready) begin
      code_valid <= 1'b0;
    end
  end

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    code_valid && !code_ready && !at_last |=> code_valid && $stable(code_word));

  p_origin_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(code_valid) |-> $past(at_last));

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    at_last && (rec_next.count == '0) |=> code_word[6:0] == 7'h7F);

  p_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    at_last |=> code_word[7] == $past(data_in));
endmodule

// File: tb/test_tem_frame_encoder.sv
module test_tem_frame_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_GAP   = 3;
  localparam int S_LO = 12, S_HI = 14, L_LO = 24, L_HI = 28;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_tick = 1'b0, frame_start = 1'b0, data_in = 1'b0;
  logic code_ready = 1'b1;
  logic code_valid;
  logic [7:0] code_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  tem_frame_encoder i_tem_frame_encoder (
    .clk, .rst_n, .slot_tick, .frame_start, .data_in,
    .code_ready, .code_valid, .code_word
  );

  int compared = 0, mismatched = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic model_lvl = 1'b0;
  bit model_hist = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic prev, input int t0, input int t1,
                                     input int t2, input int t3, input int t4);
    logic [31:0] p; logic c = prev;
    for (int i = 0; i < 32; i++) begin
      if (i == t0 || i == t1 || i == t2 || i == t3 || i == t4) c = ~c;
      p[i] = c;
    end
    return p;
  endfunction

  function automatic logic [7:0] model(input logic [31:0] pat, input logic prev, input bit hist);
    int n = 0; int s[3]; logic p = prev; bit h = hist;
    int g1, g2; logic lv = pat[31];
    s[0] = 0; s[1] = 0; s[2] = 0;
    for (int i = 0; i < 32; i++) begin
      if (h && pat[i] != p) begin
        if (n < 3) s[n] = i;
        n++;
      end
      p = pat[i]; h = 1'b1;
    end
    g1 = s[1] - s[0]; g2 = s[2] - s[1];
    if (n == 0) return {lv, 7'h7F};
    if (n == 2 && g1 >= S_LO && g1 <= S_HI && s[0] <= 17) return {lv, 2'b11, 5'(s[0])};
    if (n == 2 && g1 >= L_LO && g1 <= L_HI && s[0] >= 4) return {lv, 2'b01, 5'(s[0])};
    if (n == 2 && g1 >= L_LO && g1 <= L_HI) return {lv, 2'b00, 3'(s[1] - 24), 2'(s[0])};
    if (n == 3 && g1 >= S_LO && g1 <= S_HI && g2 >= S_LO && g2 <= S_HI && s[0] <= 4)
      return {lv, 2'b11, 5'(s[0])};
    return {lv, 2'b10, 5'(s[0])};
  endfunction

  task automatic tick(input logic d, input logic fs);
    @(negedge clk);
    data_in = d; frame_start = fs; slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0; frame_start = 1'b0;
  endtask

  // Driver: pushes the expected word, then plays the frame slot by slot.
  task automatic send_frame(input logic [31:0] pat, input bit expect_word,
                            input string req, input bit chk_timing);
    if (expect_word) begin
      exp_q.push_back(model(pat, model_lvl, model_hist));
      tag_q.push_back(req);
    end
    model_lvl = pat[31]; model_hist = 1'b1;
    for (int i = 0; i < 32; i++) begin
      tick(pat[i], i == 0);
      if (chk_timing && i == 30) chk("R2 no word before slot 31", {7'd0, code_valid}, 8'd0);
      if (chk_timing && i == 31) chk("R2 word right after slot 31", {7'd0, code_valid}, 8'd1);
      repeat (TICK_GAP) @(negedge clk);
    end
  endtask

  // Monitor: pops and compares on every accepted word.
  always @(negedge clk) begin
    if (rst_n && code_valid && code_ready && !finished) begin
      if (exp_q.size() == 0) chk("R13 unexpected word", code_word, 8'hxx);
      else chk(tag_q.pop_front(), code_word, exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset", {7'd0, code_valid}, 8'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 valid low after reset", {7'd0, code_valid}, 8'd0);

    send_frame(32'hFFFF_FFFF, 1, "R3 R5 first sample no edge", 1);
    send_frame(mk(model_lvl, 0, -1, -1, -1, -1), 1, "R3 R6 edge at slot 0 across frames", 0);
    send_frame(mk(model_lvl, 31, -1, -1, -1, -1), 1, "R4 R6 edge at slot 31", 0);
    send_frame(mk(model_lvl, 5, 18, -1, -1, -1), 1, "R7 short pair", 0);
    send_frame(mk(model_lvl, 17, 31, -1, -1, -1), 1, "R7 short pair last start", 0);
    send_frame(mk(model_lvl, 18, 31, -1, -1, -1), 1, "R11 short pair late start", 0);
    send_frame(mk(model_lvl, 4, 17, 31, -1, -1), 1, "R8 short triple", 0);
    send_frame(mk(model_lvl, 5, 18, 31, -1, -1), 1, "R11 triple late start", 0);
    send_frame(mk(model_lvl, 6, 31, -1, -1, -1), 1, "R9 long pair late", 0);
    send_frame(mk(model_lvl, 2, 28, -1, -1, -1), 1, "R10 long pair early", 0);
    send_frame(mk(model_lvl, 0, 24, -1, -1, -1), 1, "R10 long pair slot 0", 0);
    send_frame(mk(model_lvl, 2, 4, 6, 8, 10), 1, "R11 many edges", 0);
    send_frame(mk(model_lvl, 3, 9, -1, -1, -1), 1, "R11 odd spacing", 0);
    send_frame(mk(model_lvl, -1, -1, -1, -1, -1), 1, "R5 quiet frame", 1);

    // R13: cut a frame short; only the restarted full frame yields a word.
    for (int i = 0; i < 10; i++) begin
      tick(i[0], i == 0);
      model_lvl = i[0];
    end
    send_frame(mk(model_lvl, 7, -1, -1, -1, -1), 1, "R13 restarted frame", 1);

    // R12: back-pressure holds the word.
    code_ready = 1'b0;
    send_frame(mk(model_lvl, 9, -1, -1, -1, -1), 1, "R12 held word", 0);
    held = code_word;
    chk("R12 valid held", {7'd0, code_valid}, 8'd1);
    repeat (6) @(negedge clk);
    chk("R12 word stable", code_word, held);
    chk("R12 valid still held", {7'd0, code_valid}, 8'd1);
    code_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R12: a second frame overwrites a pending word.
    code_ready = 1'b0;
    send_frame(mk(model_lvl, 11, -1, -1, -1, -1), 0, "", 0);
    send_frame(mk(model_lvl, 20, -1, -1, -1, -1), 1, "R12 overwrite keeps newest", 0);
    code_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 valid dropped after accept", {7'd0, code_valid}, 8'd0);

    repeat (10) @(negedge clk);
    chk("R2 all expected words delivered", 8'(exp_q.size()), 8'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule